// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Granularity

This block watches a real-time clock's live date, hour, minute and second (each an 8-bit BCD byte) and decides, once per one-second update strobe, whether the programmed alarm time has been reached. A 4-bit repeat selector sets how coarse the match is. It can ignore every field, or compare only seconds, only seconds and minutes, everything except the date, or all four fields. A match sets a sticky alarm flag. Enable inputs decide whether that flag also raises the interrupt request.

The flag and the interrupt are cleared by a read of the flag register. The read counts only if it stays active long enough. Here that is modelled as the read strobe staying high for `RD_HOLD` consecutive clock cycles. A separate input signals battery-backup operation. While it is high, the interrupt needs a second, backup-specific enable as well as the normal one. The time counters and the register bus decode belong to neighbouring blocks. This block only consumes their values and strobes.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` and `irq` are both 0.
- R2: With `repeat_sel` = 4'b1111, every `sec_tick` sets the flag, whatever the alarm and live fields hold.
- R3: With `repeat_sel` = 4'b1110, a tick sets the flag only when the seconds bytes are equal. Minutes, hours and date are ignored.
- R4: With `repeat_sel` = 4'b1100, a tick sets the flag only when both the seconds and minutes bytes are equal.
- R5: With `repeat_sel` = 4'b1000, a tick sets the flag only when the seconds, minutes and hours bytes are equal. The date is ignored.
- R6: With `repeat_sel` = 4'b0000, a tick sets the flag only when all four bytes (date, hours, minutes, seconds) are equal.
- R7: Any other `repeat_sel` code behaves like 4'b1111 and fires on every tick.
- R8: Without `sec_tick` no comparison takes place, and the flag never rises, even when the fields match.
- R9: The flag is set on a match whatever the enables hold. When `on_backup` is 0, `irq` = `alarm_flag` AND `flag_en`.
- R10: When `on_backup` is 1, `irq` is 1 only if `alarm_flag`, `flag_en` and `backup_en` are all 1.
- R11: Holding `flag_rd` high for `RD_HOLD` (default 3) consecutive cycles clears the flag and `irq` on the edge that completes the hold. A shorter read leaves them unchanged. A read that stays high clears only once.
- R12: If a match arrives on the same edge as a clearing read, the flag stays set.
- R13: Once set, the flag stays set through later ticks, matching or not, until a qualifying read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking the one-second time update |
| now_date | input | 8 | Live day-of-month, BCD |
| now_hour | input | 8 | Live hour, BCD |
| now_min | input | 8 | Live minute, BCD |
| now_sec | input | 8 | Live second, BCD |
| alm_date | input | 8 | Alarm day-of-month, BCD |
| alm_hour | input | 8 | Alarm hour, BCD |
| alm_min | input | 8 | Alarm minute, BCD |
| alm_sec | input | 8 | Alarm second, BCD |
| repeat_sel | input | 4 | Repeat granularity code; bit i set ignores field i (0 sec, 1 min, 2 hour, 3 date) for legal codes |
| flag_en | input | 1 | Lets the alarm flag drive `irq` |
| backup_en | input | 1 | Also required for `irq` while on battery backup |
| on_backup | input | 1 | High while the system runs in battery-backup mode |
| flag_rd | input | 1 | Read strobe on the flag register |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Active-high alarm interrupt request |

## Verification
The in-line assertions check several rules on every cycle. The flag only rises after a tick and only falls after a read. It stays set unless cleared, a coincident match beats a clear, and the backup gate holds `irq` low when its enable is missing. Each read qualifier also emits at most one clear pulse per held read. The repeat modes themselves need the bench's scenarios: which field pattern matches under which code, how illegal codes fall back, and where the read hold length sits on either side of its threshold. Only those scenarios show whether the right fields were compared.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants for the alarm comparator.
// Assumes four BCD byte fields ordered sec, min, hour, date (index 0..3).
package rtc_alarm_pkg;

    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned FIELD_W    = 8;

    // Legal repeat codes; bit i set means field i is not compared.
    typedef enum logic [NUM_FIELDS-1:0] {
        RPT_FULL = 4'b0000,
        RPT_DAY  = 4'b1000,
        RPT_HOUR = 4'b1100,
        RPT_MIN  = 4'b1110,
        RPT_SEC  = 4'b1111
    } rpt_mode_e;

    localparam logic [NUM_FIELDS-1:0] IGNORE_ALL = '1;

endpackage

// File: rtl/alarm_mode_decode.sv
// Turns the repeat selector into a per-field ignore mask.
// Assumes: legal codes map straight onto the mask; every other code
// falls back to ignoring all fields (fires once per second).
module alarm_mode_decode
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0] repeat_sel,
    output logic [NUM_FIELDS-1:0] ignore_mask
);

    // Map legal codes one to one, route the rest to every-second mode.
    always_comb begin
        unique case (repeat_sel)
            RPT_FULL, RPT_DAY, RPT_HOUR, RPT_MIN, RPT_SEC: ignore_mask = repeat_sel;
            default:                                       ignore_mask = IGNORE_ALL;
        endcase
    end

    // Ignoring a finer field must imply ignoring every coarser field.
    always_comb begin
        for (int i = 0; i < NUM_FIELDS - 1; i++) begin
            AST_MASK_NESTED: assert (!ignore_mask[i] || ignore_mask[i+1]); // R7
        end
    end

endmodule

// File: rtl/alarm_field_cmp.sv
// Compares alarm fields against live fields, honouring an ignore mask.
// Assumes both vectors pack fields as {date, hour, min, sec}.
module alarm_field_cmp #(
    parameter int unsigned NFIELD = 4,
    parameter int unsigned FW     = 8
) (
    input  logic [NFIELD*FW-1:0] alarm_vec,
    input  logic [NFIELD*FW-1:0] live_vec,
    input  logic [NFIELD-1:0]    ignore_mask,
    output logic                 all_match
);

    logic [NFIELD-1:0] field_ok;

    // One equality slice per field, forced true when ignored.
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign field_ok[g] = ignore_mask[g] ||
                             (alarm_vec[g*FW +: FW] == live_vec[g*FW +: FW]);
    end

    // Match only when every field is equal or ignored.
    assign all_match = &field_ok;

endmodule

// File: rtl/alarm_read_qual.sv
// Qualifies a flag-register read: emits one clear pulse once the read
// strobe has been held for HOLD consecutive cycles.
// Assumes HOLD >= 1; a held strobe never produces a second pulse.
module alarm_read_qual #(
    parameter int unsigned HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    output logic clr
);

    localparam int unsigned CW = $clog2(HOLD + 1);

    logic [CW-1:0] held_cnt;

    // Count consecutive read cycles, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd)
            held_cnt <= '0;
        else if (held_cnt < CW'(HOLD))
            held_cnt <= held_cnt + 1'b1;
    end

    // Pulse on the edge that completes the required hold.
    assign clr = rd && (held_cnt == CW'(HOLD - 1));

    AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr); // R11

endmodule

// File: rtl/rtc_alarm_match.sv
// Alarm match block: on each one-second strobe compares the BCD alarm
// fields with live time under the selected repeat mode, keeps a sticky
// flag, and gates the interrupt with normal and backup enables.
// Assumes sec_tick is a single-cycle strobe in the clk domain and the
// enables come from a register block that clears them at power-up.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned RD_HOLD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic [7:0] now_date,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_min,
    input  logic [7:0] now_sec,
    input  logic [7:0] alm_date,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_sec,
    input  logic [3:0] repeat_sel,
    input  logic       flag_en,
    input  logic       backup_en,
    input  logic       on_backup,
    input  logic       flag_rd,
    output logic       alarm_flag,
    output logic       irq
);

    localparam int unsigned VEC_W = NUM_FIELDS * FIELD_W;

    logic [VEC_W-1:0]      alarm_vec;
    logic [VEC_W-1:0]      live_vec;
    logic [NUM_FIELDS-1:0] ignore_mask;
    logic                  fields_hit;
    logic                  rd_clear;
    logic                  irq_allowed;

    // Pack fields coarse to fine so index 0 is seconds.
    assign alarm_vec = {alm_date, alm_hour, alm_min, alm_sec};
    assign live_vec  = {now_date, now_hour, now_min, now_sec};

    alarm_mode_decode u_decode (
        .repeat_sel  (repeat_sel),
        .ignore_mask (ignore_mask)
    );

    alarm_field_cmp #(
        .NFIELD (NUM_FIELDS),
        .FW     (FIELD_W)
    ) u_cmp (
        .alarm_vec   (alarm_vec),
        .live_vec    (live_vec),
        .ignore_mask (ignore_mask),
        .all_match   (fields_hit)
    );

    alarm_read_qual #(
        .HOLD (RD_HOLD)
    ) u_rdq (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (flag_rd),
        .clr   (rd_clear)
    );

    // Sticky flag: a strobed match sets it and wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_flag <= 1'b0;
        else if (sec_tick && fields_hit)
            alarm_flag <= 1'b1;
        else if (rd_clear)
            alarm_flag <= 1'b0;
    end

    // Interrupt gate: backup mode additionally needs its own enable.
    assign irq_allowed = flag_en && (!on_backup || backup_en);
    assign irq         = alarm_flag && irq_allowed;

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && fields_hit) |=> alarm_flag); // R9
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick)); // R8
    AST_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(flag_rd)); // R11
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && fields_hit && rd_clear) |=> alarm_flag); // R12
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !rd_clear) |=> alarm_flag); // R13
    AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (on_backup && !backup_en) |-> !irq); // R10

endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;

    localparam int unsigned RD_HOLD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] now_date = '0, now_hour = '0, now_min = '0, now_sec = '0;
    logic [7:0] alm_date = '0, alm_hour = '0, alm_min = '0, alm_sec = '0;
    logic [3:0] repeat_sel = 4'b1111;
    logic       flag_en = 1'b0, backup_en = 1'b0, on_backup = 1'b0, flag_rd = 1'b0;
    logic       alarm_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_match #(.RD_HOLD(RD_HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .now_date(now_date), .now_hour(now_hour), .now_min(now_min), .now_sec(now_sec),
        .alm_date(alm_date), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .repeat_sel(repeat_sel), .flag_en(flag_en), .backup_en(backup_en),
        .on_backup(on_backup), .flag_rd(flag_rd), .alarm_flag(alarm_flag), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] rpt;
        logic [7:0] ad, ah, am, as;
        logic [7:0] nd, nh, nm, ns;
        logic       exp;
    } vec_t;

    // Fields: requirement, repeat code, alarm d/h/m/s, live d/h/m/s, expected flag.
    localparam vec_t VECS [12] = '{
        '{4'd2, 4'b1111, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R2
        '{4'd3, 4'b1110, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h02, 8'h03, 8'h45, 1'b1}, // R3
        '{4'd3, 4'b1110, 8'h12, 8'h05, 8'h30, 8'h45, 8'h12, 8'h05, 8'h30, 8'h44, 1'b0}, // R3
        '{4'd4, 4'b1100, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h02, 8'h30, 8'h45, 1'b1}, // R4
        '{4'd4, 4'b1100, 8'h12, 8'h05, 8'h30, 8'h45, 8'h12, 8'h05, 8'h31, 8'h45, 1'b0}, // R4
        '{4'd5, 4'b1000, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h05, 8'h30, 8'h45, 1'b1}, // R5
        '{4'd5, 4'b1000, 8'h12, 8'h05, 8'h30, 8'h45, 8'h12, 8'h15, 8'h30, 8'h45, 1'b0}, // R5
        '{4'd6, 4'b0000, 8'h31, 8'h23, 8'h59, 8'h59, 8'h31, 8'h23, 8'h59, 8'h59, 1'b1}, // R6
        '{4'd6, 4'b0000, 8'h31, 8'h23, 8'h59, 8'h59, 8'h30, 8'h23, 8'h59, 8'h59, 1'b0}, // R6
        '{4'd7, 4'b0101, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R7
        '{4'd7, 4'b0011, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}, // R7
        '{4'd7, 4'b1010, 8'h12, 8'h05, 8'h30, 8'h45, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1}  // R7
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Hold the read strobe for n cycles, release, sample at the next falling edge.
    task automatic do_read(input int n);
        @(negedge clk) flag_rd = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk) flag_rd = 1'b0;
    endtask

    // Apply one tick with the current fields; result visible at the next falling edge.
    task automatic one_tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic set_fields(input vec_t v);
        repeat_sel = v.rpt;
        alm_date = v.ad; alm_hour = v.ah; alm_min = v.am; alm_sec = v.as;
        now_date = v.nd; now_hour = v.nh; now_min = v.nm; now_sec = v.ns;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "flag in reset", alarm_flag, 1'b0);
        check("R1", "irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flag after reset", alarm_flag, 1'b0);
        check("R1", "irq after reset", irq, 1'b0);

        // Table walk over repeat modes.
        flag_en = 1'b1;
        foreach (VECS[i]) begin
            do_read(RD_HOLD);
            set_fields(VECS[i]);
            one_tick();
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d flag", i), alarm_flag, VECS[i].exp);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d irq", i), irq, VECS[i].exp);
        end

        // R8: matching fields without a tick leave the flag low.
        do_read(RD_HOLD);
        set_fields(VECS[7]);
        repeat (4) @(negedge clk);
        check("R8", "no tick no flag", alarm_flag, 1'b0);

        // R9: flag sets with interrupt disabled; irq follows flag_en.
        flag_en = 1'b0;
        one_tick();
        check("R9", "flag set with enable off", alarm_flag, 1'b1);
        check("R9", "irq masked", irq, 1'b0);
        flag_en = 1'b1;
        #1;
        check("R9", "irq when enabled", irq, 1'b1);

        // R10: backup gating.
        on_backup = 1'b1; backup_en = 1'b0; #1;
        check("R10", "backup without backup_en", irq, 1'b0);
        backup_en = 1'b1; #1;
        check("R10", "backup with both enables", irq, 1'b1);
        flag_en = 1'b0; #1;
        check("R10", "backup without flag_en", irq, 1'b0);
        flag_en = 1'b1; on_backup = 1'b0; backup_en = 1'b0;

        // R13: sticky through non-matching ticks.
        now_sec = 8'h00;
        one_tick();
        one_tick();
        check("R13", "flag sticky", alarm_flag, 1'b1);

        // R11: short read does nothing, full read clears.
        do_read(RD_HOLD - 1);
        check("R11", "short read keeps flag", alarm_flag, 1'b1);
        check("R11", "short read keeps irq", irq, 1'b1);
        do_read(RD_HOLD);
        check("R11", "full read clears flag", alarm_flag, 1'b0);
        check("R11", "full read clears irq", irq, 1'b0);

        // R11: a strobe held long clears only once; a later match stays.
        set_fields(VECS[7]);
        @(negedge clk) flag_rd = 1'b1;
        repeat (RD_HOLD + 1) @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        repeat (2) @(negedge clk);
        flag_rd = 1'b0;
        check("R11", "held read clears once", alarm_flag, 1'b1);

        // R12: match coincident with the clearing edge keeps flag.
        do_read(RD_HOLD);
        check("R12", "precondition cleared", alarm_flag, 1'b0);
        one_tick();
        @(negedge clk) flag_rd = 1'b1;
        repeat (RD_HOLD - 1) @(posedge clk);
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) begin sec_tick = 1'b0; flag_rd = 1'b0; end
        check("R12", "set wins over clear", alarm_flag, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule